// File: doc/BRIEF.md
# Colour Panel Controller Register File

This block is the software-visible register file of a colour LCD controller. It sits on a simple 32-bit peripheral bus that addresses whole words inside a 4 KB window. A bus master uses it to program four timing words, the base addresses of the upper and lower panel halves, and a control word. It also uses it to mask, inspect and acknowledge interrupt events, to read eight identification bytes, and to fill a 128-word palette memory. The block decodes the panel width, the panel height, the pixel-depth code and the display-enable condition from those values and drives them to the pixel pipeline as registered outputs.

A parameter chooses between two register layouts. In the original layout the interrupt mask sits at word 6 and the control word at word 7. In the newer layout the two are swapped, and the identification bytes differ. Each access is a single cycle with `bus_sel` high. Write data takes effect at that clock edge. Read data and the error flag appear on the following cycle.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every register reads zero, `panel_width` is 16, `panel_height` is 1, and `depth_mode`, `disp_en`, the three order flags and `bus_err` are 0.
- R2: Words 0 to 3 (timing) and words 4 and 5 (upper and lower base) read back the full 32-bit value last written. Read data appears one cycle after the access.
- R3: With `NEWER_MAP`=0, word 6 is the interrupt mask and word 7 is the control word. With `NEWER_MAP`=1 the two are swapped, on both read and write.
- R4: `panel_width` = ((timing0 AND 0xFC) + 4) x 4 and `panel_height` = (timing1 AND 0x3FF) + 1. Both are valid on the cycle after the timing write.
- R5: `depth_mode` is control bits [3:1]. `bgr_order` is bit 8, `be_bytes` is bit 9 and `be_pixels` is bit 10. `disp_en` is 1 only when control bit 0 (enable) and bit 11 (power) are both 1.
- R6: Each cycle, a 1 on bit i of `irq_event` sets raw status bit i. Word 8 reads the raw status, and word 9 reads raw status AND mask.
- R7: A write to word 10 clears the raw status bits that are 1 in the write data. If an event arrives in the same cycle for the same bit, the event wins and the bit stays set.
- R8: Words 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) each return one identification byte in bits [7:0]. In index order the bytes are 10 11 04 00 0D F0 05 B1 for the original layout and 11 11 24 00 0D F0 05 B1 for the newer one.
- R9: Word 11 reads the upper base value and word 12 reads the lower base value.
- R10: Words 0x80 to 0xFF (byte offsets 0x200 to 0x3FC) map to a 128-word read/write palette memory, indexed by the low 7 address bits. The palette memory is not cleared by reset.
- R11: An access is illegal in these cases: a read of word 10, a write to words 8, 9, 11 or 12 or to the identification range, and any access outside the defined words. An illegal access reads zero, changes no register, and raises `bus_err` for the one cycle after it.
- R12: Every write access, legal or not, raises `invalidate` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Illegal-access flag, the cycle after the access |
| irq_event | input | NUM_IRQ | Per-bit interrupt event pulses |
| panel_width | output | 11 | Decoded panel width in pixels |
| panel_height | output | 11 | Decoded panel height in lines |
| depth_mode | output | 3 | Pixel-depth code |
| disp_en | output | 1 | Enable and power both set |
| bgr_order | output | 1 | Blue/red swap flag |
| be_bytes | output | 1 | Big-endian byte order flag |
| be_pixels | output | 1 | Big-endian pixel order flag |
| invalidate | output | 1 | One-cycle pulse after any write |

## Verification
An event pulse on `irq_event` and a write to the clear word can land in the same clock, and both then try to update the same raw status bit. The bench drives an event and a clear write on matching bits in one cycle, and also on disjoint bits. It then reads word 8 and expects the colliding bit to stay set while the bits that were only cleared drop. A bound property checks that, after any clear write, no bit that was cleared without a simultaneous event remains set.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [1:0] {
    SPACE_REG  = 2'd0,
    SPACE_PAL  = 2'd1,
    SPACE_ID   = 2'd2,
    SPACE_NONE = 2'd3
  } space_e;

  localparam int unsigned GEO_W = 11;

  localparam logic [3:0] OFS_UPBASE = 4'd4;
  localparam logic [3:0] OFS_LPBASE = 4'd5;
  localparam logic [3:0] OFS_RAW    = 4'd8;
  localparam logic [3:0] OFS_MASKED = 4'd9;
  localparam logic [3:0] OFS_CLR    = 4'd10;
  localparam logic [3:0] OFS_UPCUR  = 4'd11;
  localparam logic [3:0] OFS_LPCUR  = 4'd12;
  localparam int unsigned NUM_REG_WORDS = 13;

  // Control word bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_BGR   = 8;
  localparam int unsigned CB_BEB   = 9;
  localparam int unsigned CB_BEP   = 10;
  localparam int unsigned CB_POWER = 11;

  function automatic logic [7:0] id_byte(input logic newer, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = newer ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = newer ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

  function automatic logic [GEO_W-1:0] calc_width(input logic [7:0] f);
    logic [GEO_W-1:0] groups;
    groups = GEO_W'(f[7:2]) + GEO_W'(1);
    return groups << 4;
  endfunction

  function automatic logic [GEO_W-1:0] calc_height(input logic [9:0] f);
    return GEO_W'(f) + GEO_W'(1);
  endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PAL_BASE  = 'h80,
  parameter int unsigned PAL_DEPTH = 128,
  parameter int unsigned ID_WORDS  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output space_e            space,
  output logic [3:0]        reg_idx,
  output logic              legal
);
  localparam logic [ADDR_W-1:0] REG_END = ADDR_W'(NUM_REG_WORDS);
  localparam logic [ADDR_W-1:0] PAL_LO  = ADDR_W'(PAL_BASE);
  localparam logic [ADDR_W-1:0] PAL_HI  = ADDR_W'(PAL_BASE + PAL_DEPTH - 1);
  localparam logic [ADDR_W-1:0] ID_LO   = ADDR_W'((1 << ADDR_W) - ID_WORDS);

  assign reg_idx = addr[3:0];

  always_comb begin
    if (addr < REG_END)                       space = SPACE_REG;
    else if (addr >= PAL_LO && addr <= PAL_HI) space = SPACE_PAL;
    else if (addr >= ID_LO)                   space = SPACE_ID;
    else                                      space = SPACE_NONE;
  end

  always_comb begin
    case (space)
      SPACE_REG: legal = wr ? (reg_idx <= 4'd7 || reg_idx == OFS_CLR)
                            : (reg_idx != OFS_CLR);
      SPACE_PAL: legal = 1'b1;
      SPACE_ID:  legal = ~wr;
      default:   legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/lcdc_palette_ram.sv
module lcdc_palette_ram #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter bit          NEWER_MAP = 1'b0,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAL_DEPTH = 128,
  parameter int unsigned NUM_IRQ   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  input  logic [NUM_IRQ-1:0] irq_event,
  output logic [GEO_W-1:0]   panel_width,
  output logic [GEO_W-1:0]   panel_height,
  output logic [2:0]         depth_mode,
  output logic               disp_en,
  output logic               bgr_order,
  output logic               be_bytes,
  output logic               be_pixels,
  output logic               invalidate
);
  localparam logic [3:0] CTRL_SLOT = NEWER_MAP ? 4'd6 : 4'd7;
  localparam logic [3:0] MASK_SLOT = NEWER_MAP ? 4'd7 : 4'd6;
  localparam int unsigned NUM_TIM  = 4;
  localparam int unsigned PAL_IDX_W = $clog2(PAL_DEPTH);

  space_e     space;
  logic [3:0] reg_idx;
  logic       legal;

  lcdc_decode #(
    .ADDR_W   (ADDR_W),
    .PAL_BASE ('h80),
    .PAL_DEPTH(PAL_DEPTH),
    .ID_WORDS (8)
  ) u_decode (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .space  (space),
    .reg_idx(reg_idx),
    .legal  (legal)
  );

  logic wr_acc, rd_acc, reg_wr;
  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;
  assign reg_wr = wr_acc & legal & (space == SPACE_REG);

  logic [DATA_W-1:0]  tim_q [NUM_TIM];
  logic [DATA_W-1:0]  upbase_q, lpbase_q, ctrl_q;
  logic [NUM_IRQ-1:0] mask_q, raw_q, clr_bits;

  assign clr_bits = (reg_wr && reg_idx == OFS_CLR) ? bus_wdata[NUM_IRQ-1:0]
                                                   : '0;

  // Register writes and derived panel state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
      upbase_q     <= '0;
      lpbase_q     <= '0;
      ctrl_q       <= '0;
      mask_q       <= '0;
      raw_q        <= '0;
      panel_width  <= calc_width(8'd0);
      panel_height <= calc_height(10'd0);
      disp_en      <= 1'b0;
    end else begin
      // events take priority over a clear in the same cycle
      raw_q <= (raw_q & ~clr_bits) | irq_event;
      if (reg_wr) begin
        for (int i = 0; i < NUM_TIM; i++)
          if (reg_idx == 4'(i)) tim_q[i] <= bus_wdata;
        if (reg_idx == 4'd0) panel_width  <= calc_width(bus_wdata[7:0]);
        if (reg_idx == 4'd1) panel_height <= calc_height(bus_wdata[9:0]);
        if (reg_idx == OFS_UPBASE) upbase_q <= bus_wdata;
        if (reg_idx == OFS_LPBASE) lpbase_q <= bus_wdata;
        if (reg_idx == MASK_SLOT)  mask_q   <= bus_wdata[NUM_IRQ-1:0];
        if (reg_idx == CTRL_SLOT) begin
          ctrl_q  <= bus_wdata;
          disp_en <= bus_wdata[CB_EN] & bus_wdata[CB_POWER];
        end
      end
    end
  end

  assign depth_mode = ctrl_q[3:1];
  assign bgr_order  = ctrl_q[CB_BGR];
  assign be_bytes   = ctrl_q[CB_BEB];
  assign be_pixels  = ctrl_q[CB_BEP];

  // Palette memory
  logic [DATA_W-1:0] pal_rdata;

  lcdc_palette_ram #(
    .DEPTH (PAL_DEPTH),
    .DATA_W(DATA_W)
  ) u_palette (
    .clk  (clk),
    .we   (wr_acc && space == SPACE_PAL),
    .idx  (bus_addr[PAL_IDX_W-1:0]),
    .wdata(bus_wdata),
    .rdata(pal_rdata)
  );

  // Read path
  logic [DATA_W-1:0] reg_word, rd_word;

  always_comb begin
    reg_word = '0;
    if (reg_idx < 4'(NUM_TIM)) reg_word = tim_q[reg_idx[1:0]];
    else if (reg_idx == OFS_UPBASE || reg_idx == OFS_UPCUR) reg_word = upbase_q;
    else if (reg_idx == OFS_LPBASE || reg_idx == OFS_LPCUR) reg_word = lpbase_q;
    else if (reg_idx == CTRL_SLOT)  reg_word = ctrl_q;
    else if (reg_idx == MASK_SLOT)  reg_word = DATA_W'(mask_q);
    else if (reg_idx == OFS_RAW)    reg_word = DATA_W'(raw_q);
    else if (reg_idx == OFS_MASKED) reg_word = DATA_W'(raw_q & mask_q);
  end

  always_comb begin
    case (space)
      SPACE_REG: rd_word = reg_word;
      SPACE_ID:  rd_word = DATA_W'(id_byte(NEWER_MAP, bus_addr[2:0]));
      default:   rd_word = '0;
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  logic              pal_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      pal_sel_q  <= 1'b0;
      bus_err    <= 1'b0;
      invalidate <= 1'b0;
    end else begin
      rdata_q    <= (rd_acc && legal) ? rd_word : '0;
      pal_sel_q  <= rd_acc && space == SPACE_PAL;
      bus_err    <= bus_sel & ~legal;
      invalidate <= wr_acc;
    end
  end

  assign bus_rdata = pal_sel_q ? pal_rdata : rdata_q;

endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_IRQ-1:0] clr_data,
  input logic [NUM_IRQ-1:0] irq_event,
  input logic [NUM_IRQ-1:0] raw,
  input logic               bus_err,
  input logic               invalidate,
  input logic               disp_en
);
  localparam logic [ADDR_W-1:0] CLR_WORD = ADDR_W'(10);

  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel)); // R11

  AST_INVAL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    invalidate |-> $past(bus_sel && bus_wr)); // R12

  AST_WRITE_GIVES_INVAL: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr) |=> invalidate); // R12

  AST_CLEAR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == CLR_WORD)
      |=> ((raw & $past(clr_data) & ~$past(irq_event)) == '0)); // R7

  AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
    (|irq_event) |=> ((raw & $past(irq_event)) == $past(irq_event))); // R6

  AST_EN_CHANGES_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_en) |-> $past(bus_sel && bus_wr)); // R5

endmodule

bind lcdc_regbank lcdc_regbank_chk #(
  .ADDR_W (ADDR_W),
  .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .clr_data  (bus_wdata[NUM_IRQ-1:0]),
  .irq_event (irq_event),
  .raw       (raw_q),
  .bus_err   (bus_err),
  .invalidate(invalidate),
  .disp_en   (disp_en)
);

// File: tb/lcdc_regbank_tb.sv
module lcdc_regbank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  irq_event = '0;

  logic [31:0] rd0, rd1;
  logic        err0, err1;
  logic [10:0] w0, h0, w1, h1;
  logic [2:0]  dm0, dm1;
  logic        en0, en1, bgr0, bgr1, beb0, beb1, bep0, bep1, inv0, inv1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  lcdc_regbank #(.NEWER_MAP(1'b0)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
    .bus_err(err0), .irq_event(irq_event), .panel_width(w0),
    .panel_height(h0), .depth_mode(dm0), .disp_en(en0),
    .bgr_order(bgr0), .be_bytes(beb0), .be_pixels(bep0), .invalidate(inv0)
  );

  lcdc_regbank #(.NEWER_MAP(1'b1)) u_dut_new (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
    .bus_err(err1), .irq_event(irq_event), .panel_width(w1),
    .panel_height(h1), .depth_mode(dm1), .disp_en(en1),
    .bgr_order(bgr1), .be_bytes(beb1), .be_pixels(bep1), .invalidate(inv1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_evt(input logic [9:0] a, input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; irq_event = ev;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; irq_event = '0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    wr_evt(a, d, 4'd0);
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 width", 32'(w0), 32'd16);
    check("R1 height", 32'(h0), 32'd1);
    check("R1 depth/en", {dm0, en0, bgr0, beb0, bep0, err0}, '0);
    rd(10'd0);  check("R1 timing0", rd0, 32'd0);
    rd(10'd7);  check("R1 control", rd0, 32'd0);
  endtask

  task automatic t_timing();
    wr(10'd0, 32'h0000_00FF); check("R4 width max", 32'(w0), 32'd1024);
    wr(10'd0, 32'h1234_5603); check("R4 width low bits ignored", 32'(w0), 32'd16);
    wr(10'd1, 32'hFFFF_FC7F); check("R4 height", 32'(h0), 32'd128);
    wr(10'd1, 32'h0000_03FF); check("R4 height max", 32'(h0), 32'd1024);
    wr(10'd2, 32'hCAFE_F00D); wr(10'd3, 32'h8000_0001);
    rd(10'd0); check("R2 timing0", rd0, 32'h1234_5603);
    rd(10'd1); check("R2 timing1", rd0, 32'h0000_03FF);
    rd(10'd2); check("R2 timing2", rd0, 32'hCAFE_F00D);
    rd(10'd3); check("R2 timing3", rd0, 32'h8000_0001);
  endtask

  task automatic t_ctrl();
    wr(10'd7, 32'h0000_070C);
    check("R5 depth", 32'(dm0), 32'd6);
    check("R5 order flags", {bgr0, beb0, bep0}, 3'b111);
    check("R5 en off", 32'(en0), 32'd0);
    wr(10'd7, 32'h0000_0001); check("R5 enable without power", 32'(en0), 32'd0);
    wr(10'd7, 32'h0000_0801); check("R5 enable with power", 32'(en0), 32'd1);
    check("R5 flags cleared", {bgr0, beb0, bep0, dm0}, '0);
    wr(10'd7, 32'h0000_0800); check("R5 power only", 32'(en0), 32'd0);
  endtask

  task automatic t_variant();
    wr(10'd6, 32'h0000_0801);
    check("R3 new slot6 is control", 32'(en1), 32'd1);
    check("R3 old slot6 is mask", 32'(en0), 32'd0);
    rd(10'd6);
    check("R3 old slot6 read", rd0, 32'd1);
    check("R3 new slot6 read", rd1, 32'h0000_0801);
    wr(10'd7, 32'h0000_0FFF);
    check("R3 old slot7 is control", 32'(en0), 32'd1);
    rd(10'd7);
    check("R3 new slot7 read mask", rd1, 32'h0000_000F);
    check("R3 old slot7 read ctrl", rd0, 32'h0000_0FFF);
    rd(10'd6);
    check("R3 new slot6 unchanged", rd1, 32'h0000_0801);
  endtask

  task automatic t_irq();
    wr(10'd6, 32'h0000_0005);
    wr_evt(10'd2, 32'hCAFE_F00D, 4'b0011);
    rd(10'd8); check("R6 raw", rd0, 32'd3);
    rd(10'd9); check("R6 masked", rd0, 32'd1);
    wr(10'd10, 32'h0000_0001);
    rd(10'd8); check("R7 clear bit0", rd0, 32'd2);
    wr_evt(10'd10, 32'h0000_0002, 4'b0010);
    rd(10'd8); check("R7 event wins over clear", rd0, 32'd2);
    wr_evt(10'd10, 32'h0000_0003, 4'b0100);
    rd(10'd8); check("R7 clear with other event", rd0, 32'd4);
    rd(10'd9); check("R6 masked after clear", rd0, 32'd4);
  endtask

  task automatic t_id();
    logic [7:0] exp_old [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] exp_new [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd(10'h3F8 + 10'(i));
      check("R8 id original", rd0, 32'(exp_old[i]));
      check("R8 id newer", rd1, 32'(exp_new[i]));
      check("R8 id no error", 32'(err0), 32'd0);
    end
  endtask

  task automatic t_curr();
    wr(10'd4, 32'hA000_1000); wr(10'd5, 32'hB000_2000);
    rd(10'd4);  check("R2 upper base", rd0, 32'hA000_1000);
    rd(10'd5);  check("R2 lower base", rd0, 32'hB000_2000);
    rd(10'd11); check("R9 upper current", rd0, 32'hA000_1000);
    rd(10'd12); check("R9 lower current", rd0, 32'hB000_2000);
  endtask

  task automatic t_palette();
    wr(10'h080, 32'hDEAD_BEEF);
    wr(10'h0FF, 32'h1234_5678);
    wr(10'h081, 32'h0F0F_0F0F);
    rd(10'h080); check("R10 palette first", rd0, 32'hDEAD_BEEF);
    check("R10 palette no error", 32'(err0), 32'd0);
    rd(10'h0FF); check("R10 palette last", rd0, 32'h1234_5678);
    rd(10'h081); check("R10 palette second", rd1, 32'h0F0F_0F0F);
  endtask

  task automatic t_undef();
    rd(10'h020); check("R11 undefined read data", rd0, 32'd0);
    check("R11 undefined read err", 32'(err0), 32'd1);
    wr(10'h020, 32'hFFFF_FFFF); check("R11 undefined write err", 32'(err0), 32'd1);
    rd(10'd10); check("R11 clear-word read", {rd0[30:0], err0}, 32'd1);
    wr(10'd8, 32'h0000_000F); check("R11 raw write err", 32'(err0), 32'd1);
    rd(10'd8); check("R11 raw unchanged", rd0, 32'd4);
    wr(10'h3F8, 32'h0000_00AA); check("R11 id write err", 32'(err0), 32'd1);
    rd(10'h3F8); check("R11 id unchanged", rd0, 32'h10);
    rd(10'd0); check("R11 timing untouched", rd0, 32'h1234_5603);
    check("R11 err one cycle", 32'(err0), 32'd0);
  endtask

  task automatic t_inval();
    wr(10'd2, 32'h0000_0001);
    check("R12 invalidate pulse", {inv0, inv1}, 2'b11);
    @(negedge clk);
    check("R12 invalidate single cycle", {inv0, inv1}, 2'b00);
    wr(10'h020, 32'h0);
    check("R12 invalidate on illegal write", 32'(inv0), 32'd1);
    rd(10'd2);
    check("R12 no invalidate on read", 32'(inv0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_ctrl();
    t_variant();
    t_irq();
    t_id();
    t_curr();
    t_palette();
    t_undef();
    t_inval();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule